// File: doc/BRIEF.md
# Host-Side Serial Converter Read Sequencer

This block is the host master for a sampling converter that is driven over three wires: a convert strobe, a shift clock and a serial data return. A start request or a periodic tick launches one complete sequence. The block raises and lowers the convert strobe with a guaranteed high width and a guaranteed low (acquisition) gap, and it clocks in the serial result MSB first. It then presents the 12-bit word for one cycle. Every interval is a count of system-clock cycles set by a parameter.

Two orderings are selectable per sequence. The read-on-wake ordering drops the strobe, shifts out the result that the converter kept while asleep, then starts a new conversion. The converter then stays asleep until the next sequence. The immediate-data ordering first acquires and converts, then reads that fresh result, then runs a dummy conversion that leaves the converter asleep. A frame-length select chooses 12 shift clocks, or 16 clocks with a check that the four extra bits are zero.

Top module: `adcrd_ctrl`

## Requirements
- R1: During and after reset, with no request, adc_conv is 1, adc_sck is 0, and busy, res_valid and res_ferr are 0. res_data is 0.
- R2: A sequence starts on a clock edge where start_req or tick is 1 while busy is 0. busy is 1 from the next cycle until the sequence ends. start_req or tick while busy is 1 has no effect. When busy is 0, adc_conv is 1 and adc_sck is 0.
- R3: Every adc_conv high interval that a sequence begins lasts exactly CONV_CYC cycles before the strobe falls or busy drops.
- R4: adc_conv stays low for at least ACQ_CYC cycles before every rise. In immediate-data mode the first low interval is exactly ACQ_CYC cycles.
- R5: adc_sck is 0 whenever adc_conv is 1. The first adc_sck rise after an adc_conv fall comes at least SETUP_CYC cycles later.
- R6: Each adc_sck high phase and each low phase between two rises of one frame lasts exactly HALF_CYC cycles.
- R7: adc_sdo is captured on adc_sck rises, MSB first. frame_long = 0 gives 12 rises per read and frame_long = 1 gives 16 rises; the result is the first 12 bits captured.
- R8: seq_fresh = 0 (read-on-wake) gives one adc_conv rise per sequence, after the read. The word read is the one converted at the end of the previous sequence.
- R9: seq_fresh = 1 (immediate data) gives two adc_conv rises per sequence. The word read is the one converted at the first rise of the same sequence. The second rise is a dummy conversion.
- R10: With frame_long = 1, res_ferr is 1 together with the result when any of the last four captured bits is 1, and 0 otherwise. With frame_long = 0, res_ferr is 0.
- R11: res_valid is a single-cycle pulse, once per sequence. res_data and res_ferr hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start one sequence |
| tick | input | 1 | Sample-rate tick, starts a sequence like start_req |
| seq_fresh | input | 1 | 1: immediate-data ordering, 0: read-on-wake |
| frame_long | input | 1 | 1: 16 shift clocks with tail check, 0: 12 clocks |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Shift clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| busy | output | 1 | Sequence in progress |
| res_data | output | 12 | Last result word |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_ferr | output | 1 | Nonzero tail bits seen in a 16-clock frame |

## Verification
The assertions watch the strobe and shift-clock timing on every cycle: the minimum high and low widths of adc_conv, the quiet shift clock during conversion, the setup gap before the first shift edge, the exact half-period widths, the count of shift edges per low phase, and the shape of the result strobe. Only the bench scenarios can show that the right word reaches res_data. A converter model in the bench shows that read-on-wake returns the previous conversion while immediate mode returns the current one. The scenarios also cover the tail check in long frames, the rejection of a retrigger while busy, and the start by tick.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

    localparam int RES_W_DEF  = 12;
    localparam int TAIL_W_DEF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_ACQ,
        ST_PRE_CONV,
        ST_WAKE,
        ST_SHIFT,
        ST_ACQ_TAIL,
        ST_CONV
    } seq_state_t;

    typedef enum logic {
        SEQ_WAKE_READ = 1'b0,
        SEQ_FRESH     = 1'b1
    } seq_mode_t;

    typedef struct packed {
        seq_mode_t mode;
        logic      long_frame;
    } seq_cfg_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adcrd_sck_gen.sv
`timescale 1ns/1ps
module adcrd_sck_gen #(
    parameter int HALF_CYC = 3,
    parameter int BIT_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BIT_W-1:0] nbits,
    output logic             sck,
    output logic             sample,
    output logic             done
);
    localparam int PH_W = adcrd_pkg::cnt_w(HALF_CYC);
    localparam logic [PH_W-1:0] PH_LOAD = PH_W'(HALF_CYC - 1);

    logic             active;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bitc;
    logic             ph_end;

    assign ph_end = (ph == '0);
    assign sample = active && ph_end && !sck;
    assign done   = active && ph_end && sck && (bitc == nbits - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= '0;
            bitc   <= '0;
            sck    <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            ph     <= PH_LOAD;
            bitc   <= '0;
            sck    <= 1'b0;
        end else if (active) begin
            if (ph_end) begin
                ph <= PH_LOAD;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck  <= 1'b0;
                    bitc <= bitc + 1'b1;
                    if (done) active <= 1'b0;
                end
            end else begin
                ph <= ph - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adcrd_capture.sv
`timescale 1ns/1ps
module adcrd_capture #(
    parameter int DATA_W = 12,
    parameter int TAIL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sample,
    input  logic              sdo,
    input  logic              long_frame,
    output logic [DATA_W-1:0] data_out,
    output logic              tail_bad
);
    localparam int FRAME_W = DATA_W + TAIL_W;

    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr) sh <= '0;
        else if (sample) sh <= {sh[FRAME_W-2:0], sdo};
    end

    generate
        if (TAIL_W > 0) begin : g_tail
            assign data_out = long_frame ? sh[FRAME_W-1:TAIL_W] : sh[DATA_W-1:0];
            assign tail_bad = long_frame && (|sh[TAIL_W-1:0]);
        end else begin : g_notail
            logic unused_long;
            assign unused_long = long_frame;
            assign data_out    = sh;
            assign tail_bad    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/adcrd_low_meter.sv
`timescale 1ns/1ps
module adcrd_low_meter #(
    parameter int ACQ_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic conv,
    output logic acq_met
);
    localparam int CW = adcrd_pkg::cnt_w(ACQ_CYC);
    localparam logic [CW-1:0] LIM = CW'(ACQ_CYC - 1);

    logic [CW-1:0] cnt;

    assign acq_met = (cnt >= LIM);

    always_ff @(posedge clk) begin
        if (rst || conv) cnt <= '0;
        else if (!acq_met) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adcrd_ctrl.sv
`timescale 1ns/1ps
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int DATA_W    = RES_W_DEF,
    parameter int TAIL_W    = TAIL_W_DEF,
    parameter int CONV_CYC  = 375,
    parameter int ACQ_CYC   = 125,
    parameter int SETUP_CYC = 4,
    parameter int HALF_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              tick,
    input  logic              seq_fresh,
    input  logic              frame_long,
    output logic              adc_conv,
    output logic              adc_sck,
    input  logic              adc_sdo,
    output logic              busy,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              res_ferr
);
    localparam int FRAME_W = DATA_W + TAIL_W;
    localparam int BIT_W   = cnt_w(FRAME_W);
    localparam int TMR_W   = cnt_w(max2(CONV_CYC, SETUP_CYC));
    localparam logic [TMR_W-1:0] CONV_LOAD  = TMR_W'(CONV_CYC - 1);
    localparam logic [TMR_W-1:0] SETUP_LOAD = TMR_W'(SETUP_CYC - 1);

    seq_state_t        st;
    seq_cfg_t          cfg;
    logic              conv_q;
    logic [TMR_W-1:0]  tmr;
    logic              tmr_zero;
    logic              acq_met;
    logic              sck_start, sck_sample, sck_done;
    logic [BIT_W-1:0]  nbits;
    logic [DATA_W-1:0] cap_data;
    logic              cap_bad;

    assign tmr_zero  = (tmr == '0);
    assign sck_start = (st == ST_WAKE) && tmr_zero;
    assign nbits     = cfg.long_frame ? BIT_W'(FRAME_W) : BIT_W'(DATA_W);
    assign adc_conv  = conv_q;
    assign busy      = (st != ST_IDLE);

    adcrd_low_meter #(.ACQ_CYC(ACQ_CYC)) u_meter (
        .clk(clk), .rst(rst), .conv(conv_q), .acq_met(acq_met)
    );

    adcrd_sck_gen #(.HALF_CYC(HALF_CYC), .BIT_W(BIT_W)) u_sck (
        .clk(clk), .rst(rst), .start(sck_start), .nbits(nbits),
        .sck(adc_sck), .sample(sck_sample), .done(sck_done)
    );

    adcrd_capture #(.DATA_W(DATA_W), .TAIL_W(TAIL_W)) u_cap (
        .clk(clk), .rst(rst), .clr(sck_start), .sample(sck_sample),
        .sdo(adc_sdo), .long_frame(cfg.long_frame),
        .data_out(cap_data), .tail_bad(cap_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cfg       <= '0;
            conv_q    <= 1'b1;
            tmr       <= '0;
            res_data  <= '0;
            res_valid <= 1'b0;
            res_ferr  <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_req || tick) begin
                        cfg.mode       <= seq_mode_t'(seq_fresh);
                        cfg.long_frame <= frame_long;
                        conv_q         <= 1'b0;
                        if (seq_fresh) begin
                            st <= ST_PRE_ACQ;
                        end else begin
                            st  <= ST_WAKE;
                            tmr <= SETUP_LOAD;
                        end
                    end
                end
                ST_PRE_ACQ: begin
                    if (acq_met) begin
                        conv_q <= 1'b1;
                        tmr    <= CONV_LOAD;
                        st     <= ST_PRE_CONV;
                    end
                end
                ST_PRE_CONV: begin
                    if (tmr_zero) begin
                        conv_q <= 1'b0;
                        tmr    <= SETUP_LOAD;
                        st     <= ST_WAKE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (tmr_zero) st <= ST_SHIFT;
                    else tmr <= tmr - 1'b1;
                end
                ST_SHIFT: begin
                    if (sck_done) begin
                        res_data  <= cap_data;
                        res_ferr  <= cap_bad;
                        res_valid <= 1'b1;
                        st        <= ST_ACQ_TAIL;
                    end
                end
                ST_ACQ_TAIL: begin
                    if (acq_met) begin
                        conv_q <= 1'b1;
                        tmr    <= CONV_LOAD;
                        st     <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (tmr_zero) st <= ST_IDLE;
                    else tmr <= tmr - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adcrd_chk.sv
`timescale 1ns/1ps
module adcrd_chk #(
    parameter int DATA_W    = 12,
    parameter int TAIL_W    = 4,
    parameter int CONV_CYC  = 375,
    parameter int ACQ_CYC   = 125,
    parameter int SETUP_CYC = 4,
    parameter int HALF_CYC  = 3
) (
    input logic clk,
    input logic rst,
    input logic adc_conv,
    input logic adc_sck,
    input logic busy,
    input logic res_valid
);
    localparam int unsigned CAP = 32'h4000_0000;

    logic        conv_p, sck_p, seen_r, seen_f;
    int unsigned hcnt, lcnt, shi, nr;
    logic        conv_rise, conv_fall, sck_rise, sck_fall;

    assign conv_rise = adc_conv && !conv_p;
    assign conv_fall = !adc_conv && conv_p;
    assign sck_rise  = adc_sck && !sck_p;
    assign sck_fall  = !adc_sck && sck_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_p <= 1'b1;
            sck_p  <= 1'b0;
            seen_r <= 1'b0;
            seen_f <= 1'b0;
            hcnt   <= 0;
            lcnt   <= 0;
            shi    <= 0;
            nr     <= 0;
        end else begin
            conv_p <= adc_conv;
            sck_p  <= adc_sck;
            if (conv_rise) seen_r <= 1'b1;
            if (conv_fall) seen_f <= 1'b1;
            if (conv_rise) hcnt <= 1;
            else if (adc_conv && hcnt < CAP) hcnt <= hcnt + 1;
            if (conv_fall) lcnt <= 1;
            else if (!adc_conv && lcnt < CAP) lcnt <= lcnt + 1;
            if (sck_rise) shi <= 1;
            else if (adc_sck && shi < CAP) shi <= shi + 1;
            if (conv_fall) nr <= 0;
            else if (sck_rise && nr < CAP) nr <= nr + 1;
        end
    end

    assert_conv_width_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_r && conv_fall) |-> (hcnt >= CONV_CYC));

    assert_acq_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_f && conv_rise) |-> (lcnt >= ACQ_CYC));

    assert_sck_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        adc_conv |-> !adc_sck);

    assert_sck_setup_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_f && sck_rise && nr == 0) |-> (lcnt >= SETUP_CYC));

    assert_sck_high_R6: assert property (@(posedge clk) disable iff (rst)
        sck_fall |-> (shi == HALF_CYC));

    assert_edge_count_R7: assert property (@(posedge clk) disable iff (rst)
        (seen_f && conv_rise) |-> (nr == 0 || nr == DATA_W || nr == DATA_W + TAIL_W));

    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (adc_conv && !adc_sck));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_valid_busy_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);
endmodule

bind adcrd_ctrl adcrd_chk #(
    .DATA_W(DATA_W), .TAIL_W(TAIL_W), .CONV_CYC(CONV_CYC),
    .ACQ_CYC(ACQ_CYC), .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC)
) u_chk (
    .clk(clk), .rst(rst), .adc_conv(adc_conv), .adc_sck(adc_sck),
    .busy(busy), .res_valid(res_valid)
);

// File: tb/sim_adcrd_ctrl.sv
`timescale 1ns/1ps
module sim_adcrd_ctrl;
    localparam int DW    = 12;
    localparam int TW    = 4;
    localparam int CONV  = 375;
    localparam int ACQ   = 125;
    localparam int SETUP = 4;
    localparam int HALF  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, tick = 1'b0, seq_fresh = 1'b0, frame_long = 1'b0;
    logic adc_conv, adc_sck, adc_sdo, busy, res_valid, res_ferr;
    logic [DW-1:0] res_data;

    always #2 clk = ~clk;

    adcrd_ctrl #(.DATA_W(DW), .TAIL_W(TW), .CONV_CYC(CONV), .ACQ_CYC(ACQ),
                 .SETUP_CYC(SETUP), .HALF_CYC(HALF)) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .tick(tick),
        .seq_fresh(seq_fresh), .frame_long(frame_long),
        .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdo(adc_sdo),
        .busy(busy), .res_data(res_data), .res_valid(res_valid), .res_ferr(res_ferr)
    );

    // converter model
    logic [DW-1:0]    ana_code = '0;
    logic [DW-1:0]    held = '0;
    logic [TW-1:0]    tail_inj = '0;
    logic [DW+TW-1:0] mshift = '0;
    always @(posedge adc_conv) held <= ana_code;
    always @(negedge adc_conv) mshift <= {held, tail_inj};
    always @(negedge adc_sck) if (!adc_conv) mshift <= {mshift[DW+TW-2:0], 1'b0};
    assign adc_sdo = adc_conv ? 1'b0 : mshift[DW+TW-1];

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // monitor, sampled on falling clock edges
    int  m_conv_rises, m_sck_rises, m_valid, hi_run, hi_min, hi_max, lo_run, lo_min;
    int  sck_hi, sck_lo, sck_bad, setup_min, fr_lo_first;
    bit  p_conv = 1'b1, p_sck = 1'b0, p_valid = 1'b0, got_first, sck_in_conv, valid_twice;

    task automatic mon_clear();
        m_conv_rises = 0; m_sck_rises = 0; m_valid = 0;
        hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30; fr_lo_first = -1;
        sck_bad = 0; setup_min = 1 << 30; sck_in_conv = 0; valid_twice = 0;
    endtask

    always @(negedge clk) if (!rst) begin
        if (adc_conv && !p_conv) begin
            m_conv_rises++;
            if (lo_run < lo_min) lo_min = lo_run;
            if (fr_lo_first < 0) fr_lo_first = lo_run;
        end
        if (!adc_conv && p_conv) got_first = 0;
        lo_run = adc_conv ? 0 : lo_run + 1;
        if (adc_conv && busy) hi_run++;
        else begin
            if (hi_run > 0) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            hi_run = 0;
        end
        if (adc_sck) begin
            if (!p_sck) begin
                m_sck_rises++;
                if (!got_first) begin
                    if (lo_run < setup_min) setup_min = lo_run;
                    got_first = 1;
                end else if (sck_lo != HALF) sck_bad++;
            end
            sck_lo = 0;
            sck_hi++;
        end else begin
            if (p_sck && sck_hi != HALF) sck_bad++;
            sck_hi = 0;
            sck_lo++;
        end
        if (adc_sck && adc_conv) sck_in_conv = 1;
        if (res_valid) m_valid++;
        if (res_valid && p_valid) valid_twice = 1;
        p_conv = adc_conv; p_sck = adc_sck; p_valid = res_valid;
    end

    logic [DW-1:0] last_conv = '0;

    task automatic run_seq(input bit fresh, input bit lng, input bit by_tick,
                           input logic [DW-1:0] code_a, input logic [DW-1:0] code_b,
                           input logic [TW-1:0] tail, input bit retrig, input bit exp_err);
        logic [DW-1:0] got, expv;
        logic          gerr;
        int            rises_done;
        got = '0; gerr = 1'b0;
        expv = fresh ? code_a : last_conv;
        @(negedge clk); #1;
        mon_clear();
        ana_code = code_a; tail_inj = tail; seq_fresh = fresh; frame_long = lng;
        if (by_tick) tick = 1'b1; else start_req = 1'b1;
        @(negedge clk); #1;
        tick = 1'b0; start_req = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (retrig) begin
                start_req = (i == 20 || i == 21);
                tick      = (i == 30);
            end
            if (res_valid) begin
                got = res_data; gerr = res_ferr; break;
            end
        end
        start_req = 1'b0; tick = 1'b0;
        ana_code = code_b;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            if (!busy) break;
        end
        rises_done = m_conv_rises;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            chk(busy == 1'b0 && adc_conv == 1'b1, "R2 stays idle after sequence", busy, 0);
        end
        if (fresh) chk(got == expv, "R9 fresh result", got, expv);
        else       chk(got == expv, "R8 previous result", got, expv);
        chk(gerr == exp_err, "R10 frame error flag", gerr, exp_err);
        chk(m_conv_rises == (fresh ? 2 : 1), fresh ? "R9 two conv rises" : "R8 one conv rise",
            m_conv_rises, fresh ? 2 : 1);
        chk(m_conv_rises == rises_done, "R2 retrigger ignored", m_conv_rises, rises_done);
        chk(m_sck_rises == (lng ? DW + TW : DW), "R7 shift clock count", m_sck_rises, lng ? DW + TW : DW);
        chk(hi_min == CONV && hi_max == CONV, "R3 conv high width", hi_min, CONV);
        chk(lo_min >= ACQ, "R4 acquisition gap", lo_min, ACQ);
        if (fresh) chk(fr_lo_first == ACQ, "R4 first gap exact", fr_lo_first, ACQ);
        chk(setup_min >= SETUP, "R5 first edge setup", setup_min, SETUP);
        chk(!sck_in_conv, "R5 sck quiet in conversion", sck_in_conv, 0);
        chk(sck_bad == 0, "R6 sck phase widths", sck_bad, 0);
        chk(m_valid == 1 && !valid_twice, "R11 single valid pulse", m_valid, 1);
        chk(res_data == expv, "R11 data held", res_data, expv);
        last_conv = code_b;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_conv == 1'b1 && adc_sck == 1'b0, "R1 pins in reset", {adc_conv, adc_sck}, 2);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(adc_conv == 1'b1 && adc_sck == 1'b0, "R1 pins after reset", {adc_conv, adc_sck}, 2);
        chk(busy == 0 && res_valid == 0 && res_ferr == 0, "R1 flags after reset",
            {busy, res_valid, res_ferr}, 0);
        chk(res_data == '0, "R1 data after reset", res_data, 0);
    endtask

    task automatic t_fresh_short();  run_seq(1, 0, 0, 12'hA5C, 12'h3C7, 4'h0, 0, 0); endtask
    task automatic t_wake_short();   run_seq(0, 0, 0, 12'h111, 12'hFFF, 4'h0, 0, 0); endtask
    task automatic t_wake_long_ok(); run_seq(0, 1, 1, 12'h222, 12'h000, 4'h0, 0, 0); endtask
    task automatic t_fresh_long_bad(); run_seq(1, 1, 0, 12'h801, 12'h7FE, 4'h4, 0, 1); endtask
    task automatic t_short_tail_ignored(); run_seq(0, 0, 0, 12'h555, 12'h9A3, 4'hF, 0, 0); endtask
    task automatic t_retrigger();    run_seq(1, 0, 0, 12'hFFF, 12'h001, 4'h0, 1, 0); endtask
    task automatic t_wake_long_bad(); run_seq(0, 1, 1, 12'h0F0, 12'h123, 4'h1, 0, 1); endtask

    bit finished = 0;
    initial begin
        mon_clear();
        t_reset();
        t_fresh_short();
        t_wake_short();
        t_wake_long_ok();
        t_fresh_long_bad();
        t_short_tail_ignored();
        t_retrigger();
        t_wake_long_bad();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule